// File: doc/BRIEF.md
# Normal-Mode Serial Audio Transmitter

This block sends audio words over a synchronous three-wire serial link made of a bit clock, a frame sync and a data line. A frame is a sequence of time slots and each slot is a programmable number of bits long. In normal mode exactly one word leaves per frame. That word always occupies slot 0, shifted out most significant bit first, and every later slot only stretches the frame with a low data line.

The bit clock either comes from an internal divider of the system clock or follows an external clock pin (gated mode). With the internal divider the clock runs continuously whenever the block is enabled, and a one-bit frame sync marks the bit just before each frame. In gated mode there is no frame sync. The transmitter starts on the first external clock edge once it has been enabled and holds a word.

The host writes words through a simple write strobe. Each word lands either in a single holding register or, when selected, in an eight-entry queue. The queue raises a request while its fill level is at or below a programmable watermark. If a frame begins with nothing to send, the previous word goes out again and a sticky underrun flag is raised.

Top module: `sat_normal_tx`

## Requirements
- R1: With `ext_sel`=0, `bclk_out` has a period of 2×(`div_val`+1) system clocks while `blk_en`=1. It is held low while `blk_en`=0.
- R2: With `ext_sel`=0, a frame lasts (`wlen_m1`+1)×(`slots_m1`+1) bit periods. `fs_out` is high for exactly the last bit period of each frame (the bit just before the first data bit of slot 0), and it changes only together with a rising `bclk_out`.
- R3: Slot 0 carries bits `wlen_m1` down to 0 of the written word, most significant first, one bit per bit period. `sd_out` changes only together with a rising `bclk_out`.
- R4: In slots 1 to `slots_m1`, `sd_out` is low.
- R5: Nothing is sent and `fs_out` stays low until `blk_en`=1, `tx_en`=1 and a word is available. Once all three hold, the next bit period is the frame-sync bit and the frame that follows carries the word.
- R6: With `fifo_en`=0, each write replaces the single holding register and each frame start empties it. `tx_req` is 1 exactly while the holding register is empty, which includes the state after reset.
- R7: With `fifo_en`=1, words are sent in write order from an 8-entry queue, and a write to a full queue is dropped. `tx_req` is 1 while the fill level is at most `wmark`.
- R8: If a frame starts with no word available, the previously sent word is sent again and `underrun` goes to 1. It stays 1 until `blk_en` or `tx_en` is deasserted.
- R9: With `ext_sel`=1, `bclk_out` follows `ext_bclk` delayed by three system clocks. Each rising edge of it advances one bit, and `fs_out` stays low.
- R10: One system clock after `blk_en` or `tx_en` goes low, `sd_out`, `fs_out` and `underrun` are 0, and the next start begins again as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Serial block enable; runs the internal bit clock |
| tx_en | input | 1 | Transmitter enable |
| ext_sel | input | 1 | 1: bit timing from `ext_bclk` (gated mode), 0: internal divider |
| ext_bclk | input | 1 | External bit clock pin |
| fifo_en | input | 1 | 1: writes go to the queue, 0: to the holding register |
| div_val | input | DIV_W | Divider setting; bit period is 2×(div_val+1) clocks |
| wlen_m1 | input | LEN_W | Bits per slot minus one (at least 1) |
| slots_m1 | input | SLOT_W | Slots per frame minus one |
| wmark | input | LVL_W | Queue watermark level |
| wr_valid | input | 1 | Write strobe for one word |
| wr_data | input | DATA_W | Word to send, right-aligned |
| sd_out | output | 1 | Serial data line |
| bclk_out | output | 1 | Bit clock |
| fs_out | output | 1 | Frame sync |
| tx_req | output | 1 | Request for more data |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The hardest state to reach from the ports is the live crossing of the queue watermark followed by a drain into underrun, because both depend on frame boundaries inside a running stream. The stimulus fills the queue past its capacity while the block is disabled, so one write is dropped. It then enables transmission and collects whole frames one at a time, aligned on the frame sync. It reads `tx_req` between frames, at the fill levels just above and at the watermark. A ninth frame then finds the queue empty and must repeat the last word with `underrun` set. Gated mode is driven by hand-toggling the external clock pin and counting its edges, since no frame sync marks the bits there.

// File: rtl/sat_pkg.sv
package sat_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_PRIME = 2'd1,
      SEQ_RUN   = 2'd2
   } seq_state_e;

endpackage

// File: rtl/sat_bitclk_gen.sv
module sat_bitclk_gen #(
   parameter int DIV_W  = 8,
   parameter int SYNC_N = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blk_en,
   input  logic             ext_sel,
   input  logic             ext_bclk,
   input  logic [DIV_W-1:0] div_val,
   output logic             bclk,
   output logic             rise_tick
);

   logic [DIV_W-1:0]  cnt_q;
   logic              half_q;
   logic [SYNC_N-1:0] sync_q;
   logic              cnt_done;
   logic              int_rise;
   logic              ext_rise;

   assign cnt_done = (cnt_q == div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (!blk_en) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (cnt_done) begin
         cnt_q  <= '0;
         half_q <= !half_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_N-2:0], ext_bclk};
   end

   assign int_rise  = blk_en && cnt_done && !half_q;
   assign ext_rise  = sync_q[SYNC_N-2] && !sync_q[SYNC_N-1];
   assign rise_tick = ext_sel ? ext_rise : int_rise;
   assign bclk      = ext_sel ? sync_q[SYNC_N-1] : half_q;

endmodule

// File: rtl/sat_tx_store.sv
module sat_tx_store #(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 8,
   parameter bit HAS_FIFO   = 1'b1,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LVL_W-1:0]  wmark,
   input  logic              pop,
   output logic              avail,
   output logic [DATA_W-1:0] head,
   output logic [LVL_W-1:0]  level,
   output logic              req
);

   localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

   logic              use_fifo;
   logic              hold_full;
   logic [DATA_W-1:0] hold_q;
   logic [LVL_W-1:0]  f_cnt;
   logic [DATA_W-1:0] f_head;

   assign use_fifo = HAS_FIFO && fifo_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_q    <= '0;
      end else if (!use_fifo && wr_valid) begin
         hold_q    <= wr_data;
         hold_full <= 1'b1;
      end else if (!use_fifo && pop) begin
         hold_full <= 1'b0;
      end
   end

   generate
      if (HAS_FIFO) begin : g_fifo
         logic [DATA_W-1:0] mem [FIFO_DEPTH];
         logic [PTR_W-1:0]  wp_q;
         logic [PTR_W-1:0]  rp_q;
         logic [LVL_W-1:0]  cnt_q;
         logic              push;
         logic              take;

         assign push = use_fifo && wr_valid && (cnt_q != LVL_W'(FIFO_DEPTH));
         assign take = use_fifo && pop && (cnt_q != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) wp_q <= (wp_q == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wp_q + 1'b1;
               if (take) rp_q <= (rp_q == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rp_q + 1'b1;
               case ({push, take})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[wp_q] <= wr_data;
         end

         assign f_cnt  = cnt_q;
         assign f_head = mem[rp_q];
      end else begin : g_no_fifo
         assign f_cnt  = '0;
         assign f_head = '0;
      end
   endgenerate

   assign avail = use_fifo ? (f_cnt != '0) : hold_full;
   assign head  = use_fifo ? f_head : hold_q;
   assign level = f_cnt;
   assign req   = use_fifo ? (f_cnt <= wmark) : !hold_full;

endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
   import sat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SLOT_W = 4,
   parameter int LEN_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              ext_sel,
   input  logic              tick,
   input  logic [LEN_W-1:0]  wlen_m1,
   input  logic [SLOT_W-1:0] slots_m1,
   input  logic              avail,
   input  logic [DATA_W-1:0] head,
   output logic              pop,
   output logic              sd,
   output logic              fs,
   output logic              underrun
);

   seq_state_e        st_q;
   logic [LEN_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_q;
   logic [DATA_W-1:0] cur_q;
   logic              sd_q, fs_q, urun_q;

   logic              bit_wrap;
   logic [LEN_W-1:0]  nxt_bit;
   logic [SLOT_W-1:0] nxt_slot;
   logic              nxt_first, nxt_last;
   logic [DATA_W-1:0] load_word, tx_word;

   assign bit_wrap  = (bit_q == wlen_m1);
   assign nxt_bit   = bit_wrap ? '0 : bit_q + 1'b1;
   assign nxt_slot  = !bit_wrap ? slot_q :
                      (slot_q == slots_m1) ? '0 : slot_q + 1'b1;
   assign nxt_first = (nxt_bit == '0) && (nxt_slot == '0);
   assign nxt_last  = (nxt_bit == wlen_m1) && (nxt_slot == slots_m1);
   assign load_word = avail ? head : cur_q;
   assign tx_word   = nxt_first ? load_word : cur_q;
   assign pop       = go && (st_q == SEQ_RUN) && tick && nxt_first && avail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         bit_q  <= '0;
         slot_q <= '0;
         cur_q  <= '0;
         sd_q   <= 1'b0;
         fs_q   <= 1'b0;
         urun_q <= 1'b0;
      end else if (!go) begin
         st_q   <= SEQ_IDLE;
         bit_q  <= wlen_m1;
         slot_q <= slots_m1;
         sd_q   <= 1'b0;
         fs_q   <= 1'b0;
         urun_q <= 1'b0;
      end else begin
         case (st_q)
            SEQ_IDLE: begin
               bit_q  <= wlen_m1;
               slot_q <= slots_m1;
               if (avail) st_q <= SEQ_PRIME;
            end
            SEQ_PRIME: begin
               if (tick) begin
                  fs_q <= !ext_sel;
                  sd_q <= 1'b0;
                  st_q <= SEQ_RUN;
               end
            end
            default: begin
               if (tick) begin
                  bit_q  <= nxt_bit;
                  slot_q <= nxt_slot;
                  fs_q   <= !ext_sel && nxt_last;
                  sd_q   <= (nxt_slot == '0) ? tx_word[wlen_m1 - nxt_bit] : 1'b0;
                  if (nxt_first) begin
                     cur_q <= load_word;
                     if (!avail) urun_q <= 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign sd       = sd_q;
   assign fs       = fs_q;
   assign underrun = urun_q;

endmodule

// File: rtl/sat_normal_tx.sv
module sat_normal_tx #(
   parameter int DATA_W     = 32,
   parameter int DIV_W      = 8,
   parameter int SLOT_W     = 4,
   parameter int FIFO_DEPTH = 8,
   parameter bit HAS_FIFO   = 1'b1,
   parameter int SYNC_N     = 3,
   parameter int LEN_W      = $clog2(DATA_W),
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en,
   input  logic              tx_en,
   input  logic              ext_sel,
   input  logic              ext_bclk,
   input  logic              fifo_en,
   input  logic [DIV_W-1:0]  div_val,
   input  logic [LEN_W-1:0]  wlen_m1,
   input  logic [SLOT_W-1:0] slots_m1,
   input  logic [LVL_W-1:0]  wmark,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sd_out,
   output logic              bclk_out,
   output logic              fs_out,
   output logic              tx_req,
   output logic              underrun
);

   generate
      if (DATA_W < 2)             begin : g_bad_data_w  $error("DATA_W must be at least 2"); end
      if ((1 << LEN_W) < DATA_W)  begin : g_bad_len_w   $error("LEN_W too narrow for DATA_W"); end
      if (DIV_W < 1)              begin : g_bad_div_w   $error("DIV_W must be at least 1"); end
      if (SLOT_W < 1)             begin : g_bad_slot_w  $error("SLOT_W must be at least 1"); end
      if (FIFO_DEPTH < 2)         begin : g_bad_depth   $error("FIFO_DEPTH must be at least 2"); end
      if (SYNC_N < 2)             begin : g_bad_sync    $error("SYNC_N must be at least 2"); end
   endgenerate

   logic              go;
   logic              tick;
   logic              pop;
   logic              avail;
   logic [DATA_W-1:0] head;
   logic [LVL_W-1:0]  fill_level;

   assign go = blk_en && tx_en;

   sat_bitclk_gen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_en    (blk_en),
      .ext_sel   (ext_sel),
      .ext_bclk  (ext_bclk),
      .div_val   (div_val),
      .bclk      (bclk_out),
      .rise_tick (tick)
   );

   sat_tx_store #(
      .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .HAS_FIFO(HAS_FIFO), .LVL_W(LVL_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .fifo_en  (fifo_en),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .wmark    (wmark),
      .pop      (pop),
      .avail    (avail),
      .head     (head),
      .level    (fill_level),
      .req      (tx_req)
   );

   sat_frame_seq #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .ext_sel  (ext_sel),
      .tick     (tick),
      .wlen_m1  (wlen_m1),
      .slots_m1 (slots_m1),
      .avail    (avail),
      .head     (head),
      .pop      (pop),
      .sd       (sd_out),
      .fs       (fs_out),
      .underrun (underrun)
   );

endmodule

// File: rtl/sat_normal_tx_chk.sv
module sat_normal_tx_chk #(
   parameter int FIFO_DEPTH = 8,
   parameter int LVL_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             blk_en,
   input logic             tx_en,
   input logic             ext_sel,
   input logic             bclk_out,
   input logic             fs_out,
   input logic             sd_out,
   input logic             underrun,
   input logic [LVL_W-1:0] fill_level
);

   // R2: frame sync only moves with a rising bit clock
   p_fs_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(blk_en && tx_en) && blk_en && tx_en && !$rose(bclk_out)) |-> $stable(fs_out));

   // R3: serial data only moves with a rising bit clock
   p_sd_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(blk_en && tx_en) && blk_en && tx_en && !$rose(bclk_out)) |-> $stable(sd_out));

   // R10: outputs quiet after a disable
   p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(blk_en && tx_en)) |-> (!fs_out && !sd_out && !underrun));

   // R1: internal bit clock parked low while the block is off
   p_bclk_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_sel && $past(!blk_en)) |-> !bclk_out);

   // R8: underrun is sticky while enabled
   p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && blk_en && tx_en) |=> underrun);

   // R7: queue never exceeds its depth
   p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= LVL_W'(FIFO_DEPTH));

endmodule

bind sat_normal_tx sat_normal_tx_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .blk_en     (blk_en),
   .tx_en      (tx_en),
   .ext_sel    (ext_sel),
   .bclk_out   (bclk_out),
   .fs_out     (fs_out),
   .sd_out     (sd_out),
   .underrun   (underrun),
   .fill_level (fill_level)
);

// File: tb/tb_sat_normal_tx.sv
`timescale 1ns/1ps
module tb_sat_normal_tx;

   localparam int DATA_W     = 32;
   localparam int DIV_W      = 8;
   localparam int SLOT_W     = 4;
   localparam int FIFO_DEPTH = 8;
   localparam int LEN_W      = $clog2(DATA_W);
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

   typedef struct packed {
      logic [7:0]  dv;
      logic [4:0]  wl;
      logic [3:0]  sl;
      logic [31:0] w;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{8'd0, 5'd7,  4'd0, 32'h0000_00A5},
      '{8'd1, 5'd15, 4'd2, 32'h1234_C3F0},
      '{8'd2, 5'd31, 4'd1, 32'h8000_0001},
      '{8'd0, 5'd1,  4'd3, 32'h0000_0002}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n, blk_en, tx_en, ext_sel, ext_bclk, fifo_en, wr_valid;
   logic [DIV_W-1:0]  div_val;
   logic [LEN_W-1:0]  wlen_m1;
   logic [SLOT_W-1:0] slots_m1;
   logic [LVL_W-1:0]  wmark;
   logic [DATA_W-1:0] wr_data;
   logic              sd_out, bclk_out, fs_out, tx_req, underrun;

   sat_normal_tx dut (
      .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .tx_en(tx_en), .ext_sel(ext_sel),
      .ext_bclk(ext_bclk), .fifo_en(fifo_en), .div_val(div_val), .wlen_m1(wlen_m1),
      .slots_m1(slots_m1), .wmark(wmark), .wr_valid(wr_valid), .wr_data(wr_data),
      .sd_out(sd_out), .bclk_out(bclk_out), .fs_out(fs_out), .tx_req(tx_req),
      .underrun(underrun)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] w);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = w;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic next_bit(output logic f, output logic s);
      @(posedge bclk_out);
      #1;
      f = fs_out;
      s = sd_out;
   endtask

   task automatic wait_fs(output bit seen);
      logic f, s;
      seen = 1'b0;
      for (int i = 0; i < 600 && !seen; i++) begin
         next_bit(f, s);
         if (f) seen = 1'b1;
      end
   endtask

   task automatic grab(input int wl, output logic [31:0] word, output int len, output bit stray);
      logic f, s;
      word = '0; len = 0; stray = 1'b0; f = 1'b0;
      while (!f && len < 2000) begin
         next_bit(f, s);
         len++;
         if (len <= wl) word = {word[30:0], s};
         else           stray = stray | s;
      end
   endtask

   task automatic off();
      @(negedge clk);
      blk_en = 1'b0;
      tx_en  = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] word;
      logic [63:0] mask;
      int          len, fs_cnt;
      bit          stray, seen;
      time         t0;
      logic        f, s;

      rst_n = 1'b0; blk_en = 1'b0; tx_en = 1'b0; ext_sel = 1'b0; ext_bclk = 1'b0;
      fifo_en = 1'b0; div_val = '0; wlen_m1 = 5'd7; slots_m1 = '0; wmark = '0;
      wr_valid = 1'b0; wr_data = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 bclk low after reset", bclk_out, 0);
      chk("R10 sd low after reset", sd_out, 0);
      chk("R10 fs low after reset", fs_out, 0);
      chk("R8 underrun clear after reset", underrun, 0);
      chk("R6 req with empty holding register", tx_req, 1);

      // table walk: divider, word length, slot count, data
      for (int v = 0; v < 4; v++) begin
         off();
         div_val  = VECS[v].dv;
         wlen_m1  = VECS[v].wl;
         slots_m1 = VECS[v].sl;
         fifo_en  = 1'b0;
         put(VECS[v].w);
         chk("R6 req drops when holding full", tx_req, 0);
         @(negedge clk);
         blk_en = 1'b1;
         tx_en  = 1'b1;
         wait_fs(seen);
         chk("R2 frame sync seen", seen, 1);
         grab(int'(VECS[v].wl) + 1, word, len, stray);
         mask = (64'd1 << (int'(VECS[v].wl) + 1)) - 64'd1;
         chk("R3 slot0 word", word, VECS[v].w & mask[31:0]);
         chk("R2 frame length", len, (int'(VECS[v].wl) + 1) * (int'(VECS[v].sl) + 1));
         chk("R4 later slots low", stray, 0);
         chk("R6 req after frame start", tx_req, 1);
         @(posedge bclk_out);
         t0 = $time;
         @(posedge bclk_out);
         chk("R1 bit period", 32'(($time - t0) / 4), 2 * (int'(VECS[v].dv) + 1));
      end

      // R5: no start without a word
      off();
      div_val = 8'd3; wlen_m1 = 5'd7; slots_m1 = 4'd0; fifo_en = 1'b0;
      @(negedge clk);
      blk_en = 1'b1;
      tx_en  = 1'b1;
      fs_cnt = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (fs_out || sd_out) fs_cnt++;
      end
      chk("R5 idle without word", fs_cnt, 0);
      put(32'h3C);
      wait_fs(seen);
      chk("R5 starts once word written", seen, 1);
      grab(8, word, len, stray);
      chk("R5 first word", word, 32'h3C);
      chk("R8 no underrun yet", underrun, 0);

      // R8: underrun repeats the last word and sticks
      grab(8, word, len, stray);
      chk("R8 repeated word", word, 32'h3C);
      chk("R8 underrun set", underrun, 1);
      put(32'h5A);
      grab(8, word, len, stray);
      chk("R8 new word after refill", word, 32'h5A);
      chk("R8 underrun sticky", underrun, 1);

      // R10: disable clears outputs
      @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk("R10 underrun cleared", underrun, 0);
      chk("R10 fs low when off", fs_out, 0);
      chk("R10 sd low when off", sd_out, 0);

      // R7: queue order, overflow drop, watermark
      off();
      fifo_en = 1'b1; wmark = 4'd2;
      @(negedge clk);
      chk("R7 req at empty queue", tx_req, 1);
      for (int k = 1; k <= 3; k++) put(32'h10 + k);
      chk("R7 req off above watermark", tx_req, 0);
      for (int k = 4; k <= 9; k++) put(32'h10 + k);
      @(negedge clk);
      blk_en = 1'b1;
      tx_en  = 1'b1;
      wait_fs(seen);
      for (int k = 1; k <= 8; k++) begin
         grab(8, word, len, stray);
         chk("R7 queue order", word, 32'h10 + k);
         if (k == 5) chk("R7 req off at level 3", tx_req, 0);
         if (k == 6) chk("R7 req on at level 2", tx_req, 1);
      end
      chk("R8 no underrun while queue held data", underrun, 0);
      grab(8, word, len, stray);
      chk("R7 full-queue write dropped", word, 32'h18);
      chk("R8 underrun after drain", underrun, 1);

      // R9: gated mode from external clock
      off();
      fifo_en = 1'b0; ext_sel = 1'b1; wlen_m1 = 5'd7; slots_m1 = 4'd1;
      put(32'h96);
      @(negedge clk);
      blk_en = 1'b1;
      tx_en  = 1'b1;
      repeat (2) @(negedge clk);
      word = '0; stray = 1'b0; fs_cnt = 0;
      for (int p = 0; p < 17; p++) begin
         ext_bclk = 1'b1;
         repeat (5) @(negedge clk);
         f = fs_out; s = sd_out;
         if (p == 0) chk("R9 bclk follows pin high", bclk_out, 1);
         if (f) fs_cnt++;
         if (p >= 1 && p <= 8) word = {word[30:0], s};
         else                  stray = stray | s;
         ext_bclk = 1'b0;
         repeat (5) @(negedge clk);
         if (p == 0) chk("R9 bclk follows pin low", bclk_out, 0);
      end
      chk("R9 gated word", word, 32'h96);
      chk("R9 gated idle slot low", stray, 0);
      chk("R9 no frame sync in gated mode", fs_cnt, 0);
      off();
      ext_sel = 1'b0;
      @(negedge clk);
      chk("R1 bclk parked after disable", bclk_out, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule